// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits in front of a CAN protocol engine and decides which of three transmit mailboxes goes out next. Software raises a mailbox's transmit request by writing 1 to its bit of the pending register. It can withdraw a request through a cancel register. A separate retransmit-disable flag turns a failed frame into an abort instead of a retry. The scheduler picks one eligible mailbox when the bus is free and commits it to a temporary transmit slot. It then asks the engine to start the frame. From then on it follows the engine's outcome strobes and updates the per-mailbox flags.

After commitment the frame in flight cannot be withdrawn. Cancel writes to that mailbox, and any change of the retransmit-disable flag, take effect only from the next arbitration. The retransmit-disable value is captured at commit time. After an arbitration loss, the scheduler waits for the engine to report that the incoming frame has completed before it arbitrates again. Mailbox k (k = 1..3) is bit k-1 of every mailbox vector.

Top module: `can_tx_sched`

## Requirements
- R1: A synchronous active-low reset clears pending, cancel, transmit-ack, abort-ack, the empty interrupt and the retransmit-disable flag. It returns the scheduler to idle: `busy` = 0, `tx_start` = 0, `tx_sel` = 0.
- R2: Writing 1 to a bit of `set_wr` sets that mailbox's pending bit, and writing 1 to a bit of `cancel_wr` sets its cancel bit, on the next clock edge. A software set wins over a hardware clear in the same cycle.
- R3: While idle with `bus_idle` high, the lowest-index mailbox that is pending with its cancel bit clear is committed. `tx_start` is high for that cycle and `tx_sel` is one-hot on that mailbox. `busy` rises on the next edge.
- R4: At an arbitration, every mailbox that is pending with its cancel bit set is aborted without being sent. Its pending and cancel bits are cleared, its abort-ack bit is set and the empty interrupt is set.
- R5: While a mailbox is committed, writing its cancel bit does not stop the frame. `tx_sel` holds its value until the engine reports an outcome, and a later `tx_done` still acknowledges it.
- R6: The retransmit-disable flag (`dis_wr` strobe, `dis_val` value) is sampled at commit. Writes made while the frame is in flight do not change how that frame's failure is handled.
- R7: When `tx_done` arrives while transmitting, the block clears the mailbox's pending and cancel bits, sets its transmit-ack bit and sets the empty interrupt. The scheduler then returns to idle. `tx_done` takes priority over `bus_err`, and `bus_err` takes priority over `arb_lost`.
- R8: When `arb_lost` or `bus_err` arrives and the captured disable value is 1, the block clears the mailbox's pending bit, sets its abort-ack bit and sets the empty interrupt.
- R9: When `arb_lost` or `bus_err` arrives and the captured disable value is 0, all flags are left unchanged. The mailbox stays pending and takes part in the next arbitration.
- R10: After `arb_lost`, no arbitration and no `tx_start` occur, even with `bus_idle` high, until `rx_done` has been seen.
- R11: Pending and cancel writes to other mailboxes while a frame is in flight do not disturb it. They are applied at the next arbitration.
- R12: Writing 1 to a bit of `txack_clr`, `abtack_clr` or `irq_clr` clears that flag. A hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_wr | input | N_MB | Write-1-to-set transmit request per mailbox |
| cancel_wr | input | N_MB | Write-1-to-set cancel request per mailbox |
| dis_wr | input | 1 | Write strobe for the retransmit-disable flag |
| dis_val | input | 1 | Value written to the retransmit-disable flag |
| txack_clr | input | N_MB | Write-1-to-clear transmit-ack bits |
| abtack_clr | input | N_MB | Write-1-to-clear abort-ack bits |
| irq_clr | input | 1 | Write-1-to-clear empty interrupt |
| bus_idle | input | 1 | Engine reports bus idle / intermission over |
| tx_done | input | 1 | Engine: frame sent successfully |
| arb_lost | input | 1 | Engine: arbitration lost |
| bus_err | input | 1 | Engine: bus error during the frame |
| rx_done | input | 1 | Engine: received frame completed normally |
| tx_start | output | 1 | Start-of-frame request for the committed mailbox |
| tx_sel | output | N_MB | One-hot committed mailbox |
| busy | output | 1 | A frame is in flight or a received frame is awaited |
| pending | output | N_MB | Pending transmit requests |
| cancel | output | N_MB | Cancel requests |
| tx_ack | output | N_MB | Transmit-acknowledge flags |
| abort_ack | output | N_MB | Abort-acknowledge flags |
| empty_irq | output | 1 | Empty-mailbox interrupt flag |

## Verification
The bench cancels a mailbox after it has been committed and checks that the frame still completes. A design that honoured the cancel late would abort a frame that is already on the wire. It flips the retransmit-disable flag in the middle of a frame, where a design that reads the live flag would retry a frame meant to be dropped, or drop one meant to be retried. It holds `bus_idle` high during the wait that follows a lost arbitration, so an early restart shows up as a stray `tx_start`. It also raises several outcome strobes together with a software clear in the same cycle, which exposes a wrong priority or a clear that beats a hardware set.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TX     = 2'd1,
    ST_RXWAIT = 2'd2
  } sched_st_t;

  localparam int DEF_MB = 3;
endpackage

// File: rtl/can_txs_arb.sv
module can_txs_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         vld
);
  // lowest index wins
  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign vld = |req;
endmodule

// File: rtl/can_txs_flags.sv
module can_txs_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_wr,
  input  logic [N-1:0] cancel_wr,
  input  logic         dis_wr,
  input  logic         dis_val,
  input  logic [N-1:0] txack_clr,
  input  logic [N-1:0] abtack_clr,
  input  logic         irq_clr,
  input  logic [N-1:0] hw_done,
  input  logic [N-1:0] hw_abort,
  output logic [N-1:0] pending,
  output logic [N-1:0] cancel,
  output logic [N-1:0] tx_ack,
  output logic [N-1:0] abort_ack,
  output logic         empty_irq,
  output logic         dis_q
);
  logic [N-1:0] retire;
  assign retire = hw_done | hw_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= '0;
      cancel    <= '0;
      tx_ack    <= '0;
      abort_ack <= '0;
      empty_irq <= 1'b0;
      dis_q     <= 1'b0;
    end else begin
      pending   <= (pending & ~retire) | set_wr;
      cancel    <= (cancel & ~retire) | cancel_wr;
      tx_ack    <= (tx_ack & ~txack_clr) | hw_done;
      abort_ack <= (abort_ack & ~abtack_clr) | hw_abort;
      empty_irq <= (empty_irq & ~irq_clr) | (|retire);
      if (dis_wr) dis_q <= dis_val;
    end
  end
endmodule

// File: rtl/can_txs_ctrl.sv
module can_txs_ctrl
  import can_txs_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_idle,
  input  logic [N-1:0] cand,
  input  logic         cand_vld,
  input  logic         dis_q,
  input  logic         tx_done,
  input  logic         arb_lost,
  input  logic         bus_err,
  input  logic         rx_done,
  output logic         arb_go,
  output logic         tx_start,
  output logic [N-1:0] tx_sel,
  output logic         busy,
  output logic         rx_wait,
  output logic [N-1:0] ev_done,
  output logic [N-1:0] ev_fail_abort
);
  sched_st_t    st_q;
  logic [N-1:0] cur_q;
  logic         dis_h_q;
  logic         in_tx, fail;

  assign in_tx    = (st_q == ST_TX);
  assign rx_wait  = (st_q == ST_RXWAIT);
  assign busy     = (st_q != ST_IDLE);
  assign arb_go   = (st_q == ST_IDLE) && bus_idle;
  assign tx_start = arb_go && cand_vld;
  assign tx_sel   = busy ? cur_q : (tx_start ? cand : '0);
  assign fail     = in_tx && !tx_done && (bus_err || arb_lost);
  assign ev_done       = (in_tx && tx_done) ? cur_q : '0;
  assign ev_fail_abort = (fail && dis_h_q) ? cur_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      dis_h_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (tx_start) begin
          st_q    <= ST_TX;
          cur_q   <= cand;
          dis_h_q <= dis_q;
        end
        ST_TX: begin
          if (tx_done || bus_err) st_q <= ST_IDLE;
          else if (arb_lost)      st_q <= ST_RXWAIT;
        end
        ST_RXWAIT: if (rx_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_txs_pkg::*;
#(
  parameter int N_MB = DEF_MB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_MB-1:0] set_wr,
  input  logic [N_MB-1:0] cancel_wr,
  input  logic            dis_wr,
  input  logic            dis_val,
  input  logic [N_MB-1:0] txack_clr,
  input  logic [N_MB-1:0] abtack_clr,
  input  logic            irq_clr,
  input  logic            bus_idle,
  input  logic            tx_done,
  input  logic            arb_lost,
  input  logic            bus_err,
  input  logic            rx_done,
  output logic            tx_start,
  output logic [N_MB-1:0] tx_sel,
  output logic            busy,
  output logic [N_MB-1:0] pending,
  output logic [N_MB-1:0] cancel,
  output logic [N_MB-1:0] tx_ack,
  output logic [N_MB-1:0] abort_ack,
  output logic            empty_irq
);
  logic [N_MB-1:0] eligible, cand, ev_done, ev_fail_abort, cxl_abort, hw_abort;
  logic            cand_vld, arb_go, rx_wait, dis_q;

  assign eligible  = pending & ~cancel;
  assign cxl_abort = arb_go ? (pending & cancel) : '0;
  assign hw_abort  = cxl_abort | ev_fail_abort;

  can_txs_arb #(.N(N_MB)) arb_i (
    .req(eligible), .gnt(cand), .vld(cand_vld)
  );

  can_txs_ctrl #(.N(N_MB)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .cand(cand), .cand_vld(cand_vld),
    .dis_q(dis_q), .tx_done(tx_done), .arb_lost(arb_lost), .bus_err(bus_err),
    .rx_done(rx_done), .arb_go(arb_go), .tx_start(tx_start), .tx_sel(tx_sel),
    .busy(busy), .rx_wait(rx_wait), .ev_done(ev_done), .ev_fail_abort(ev_fail_abort)
  );

  can_txs_flags #(.N(N_MB)) flags_i (
    .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .cancel_wr(cancel_wr),
    .dis_wr(dis_wr), .dis_val(dis_val), .txack_clr(txack_clr),
    .abtack_clr(abtack_clr), .irq_clr(irq_clr), .hw_done(ev_done),
    .hw_abort(hw_abort), .pending(pending), .cancel(cancel), .tx_ack(tx_ack),
    .abort_ack(abort_ack), .empty_irq(empty_irq), .dis_q(dis_q)
  );
endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_start,
  input logic [N-1:0] tx_sel,
  input logic         busy,
  input logic         rx_wait,
  input logic         tx_done,
  input logic         rx_done,
  input logic [N-1:0] set_wr,
  input logic [N-1:0] pending,
  input logic [N-1:0] cancel
);
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $onehot(tx_sel)); // R3
  AST_START_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ((((tx_sel - 1'b1) & pending & ~cancel) == '0) && ((tx_sel & cancel) == '0))); // R3
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tx_sel)); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rx_wait && tx_done) |=> ((pending & $past(tx_sel & ~set_wr)) == '0)); // R7
  AST_RXWAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wait && !rx_done) |=> !tx_start); // R10
endmodule

bind can_tx_sched can_tx_sched_chk #(.N(N_MB)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_sel(tx_sel), .busy(busy),
  .rx_wait(rx_wait), .tx_done(tx_done), .rx_done(rx_done), .set_wr(set_wr),
  .pending(pending), .cancel(cancel)
);

// File: tb/can_tx_sched_tb_top.sv
module can_tx_sched_tb_top;
  localparam int N = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] set_wr = '0, cancel_wr = '0, txack_clr = '0, abtack_clr = '0;
  logic dis_wr = 0, dis_val = 0, irq_clr = 0, bus_idle = 0;
  logic tx_done = 0, arb_lost = 0, bus_err = 0, rx_done = 0;
  logic tx_start, busy, empty_irq;
  logic [N-1:0] tx_sel, pending, cancel, tx_ack, abort_ack;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_tx_sched #(.N_MB(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .cancel_wr(cancel_wr),
    .dis_wr(dis_wr), .dis_val(dis_val), .txack_clr(txack_clr),
    .abtack_clr(abtack_clr), .irq_clr(irq_clr), .bus_idle(bus_idle),
    .tx_done(tx_done), .arb_lost(arb_lost), .bus_err(bus_err), .rx_done(rx_done),
    .tx_start(tx_start), .tx_sel(tx_sel), .busy(busy), .pending(pending),
    .cancel(cancel), .tx_ack(tx_ack), .abort_ack(abort_ack), .empty_irq(empty_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock edge; inputs change 1ns after it
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_strobes();
    set_wr = '0; cancel_wr = '0; txack_clr = '0; abtack_clr = '0;
    dis_wr = 0; irq_clr = 0; tx_done = 0; arb_lost = 0; bus_err = 0; rx_done = 0;
  endtask

  task automatic wipe_flags();
    txack_clr = '1; abtack_clr = '1; irq_clr = 1; tick(); clear_strobes();
  endtask

  task automatic t_reset();
    chk("R1 pending", pending, 0);   chk("R1 cancel", cancel, 0);
    chk("R1 tx_ack", tx_ack, 0);     chk("R1 abort_ack", abort_ack, 0);
    chk("R1 irq", empty_irq, 0);     chk("R1 busy", busy, 0);
    chk("R1 tx_sel", tx_sel, 0);     chk("R1 tx_start", tx_start, 0);
  endtask

  task automatic t_basic();
    set_wr = 3'b110; tick(); clear_strobes();
    chk("R2 pending set", pending, 3'b110);
    bus_idle = 1; #1;
    chk("R3 start", tx_start, 1); chk("R3 lowest sel", tx_sel, 3'b010);
    tick(); bus_idle = 0;
    chk("R3 busy", busy, 1);
    cancel_wr = 3'b010; tick(); clear_strobes();
    chk("R5 cancel stored", cancel, 3'b010); chk("R5 sel held", tx_sel, 3'b010);
    chk("R5 still busy", busy, 1);
    tx_done = 1; tick(); clear_strobes();
    chk("R7 pending", pending, 3'b100); chk("R7 tx_ack", tx_ack, 3'b010);
    chk("R7 irq", empty_irq, 1); chk("R7 cancel cleared", cancel, 0);
    chk("R5 no abort", abort_ack, 0); chk("R7 idle", busy, 0);
    txack_clr = 3'b010; irq_clr = 1; tick(); clear_strobes();
    chk("R12 tx_ack cleared", tx_ack, 0); chk("R12 irq cleared", empty_irq, 0);
    bus_idle = 1; #1; chk("R3 next sel", tx_sel, 3'b100);
    tick(); bus_idle = 0; tx_done = 1; tick(); clear_strobes();
    chk("R7 mb3 done", tx_ack, 3'b100);
    wipe_flags();
  endtask

  task automatic t_cancel_uncommitted();
    set_wr = 3'b011; cancel_wr = 3'b001; tick(); clear_strobes();
    bus_idle = 1; #1;
    chk("R4 skips cancelled", tx_sel, 3'b010);
    tick(); bus_idle = 0;
    chk("R4 pending", pending, 3'b010); chk("R4 abort_ack", abort_ack, 3'b001);
    chk("R4 cancel", cancel, 0); chk("R4 irq", empty_irq, 1);
    tx_done = 1; tick(); clear_strobes();
    wipe_flags();
  endtask

  task automatic t_dis_abort();
    dis_wr = 1; dis_val = 1; tick(); clear_strobes();
    set_wr = 3'b001; tick(); clear_strobes();
    bus_idle = 1; tick(); bus_idle = 0;
    dis_wr = 1; dis_val = 0; tick(); clear_strobes();
    bus_err = 1; tick(); clear_strobes();
    chk("R8 pending", pending, 0); chk("R8 abort_ack", abort_ack, 3'b001);
    chk("R8 irq", empty_irq, 1); chk("R6 held 1 used", busy, 0);
    wipe_flags();
  endtask

  task automatic t_retry();
    set_wr = 3'b100; tick(); clear_strobes();
    bus_idle = 1; tick();
    dis_wr = 1; dis_val = 1; tick(); clear_strobes();
    arb_lost = 1; tick(); clear_strobes();
    chk("R9 pending kept", pending, 3'b100); chk("R6 held 0 used", abort_ack, 0);
    chk("R9 no irq", empty_irq, 0); chk("R10 waiting", busy, 1);
    #1 chk("R10 no start", tx_start, 0);
    tick(); chk("R10 no start later", tx_start, 0);
    rx_done = 1; tick(); clear_strobes();
    #1 chk("R9 retried", tx_start, 1); chk("R9 retry sel", tx_sel, 3'b100);
    tick(); bus_idle = 0;
    dis_wr = 1; dis_val = 0; tx_done = 1; tick(); clear_strobes();
    chk("R9 finally sent", tx_ack, 3'b100);
    wipe_flags();
  endtask

  task automatic t_mid_flight();
    set_wr = 3'b100; tick(); clear_strobes();
    bus_idle = 1; tick(); bus_idle = 0;
    set_wr = 3'b011; cancel_wr = 3'b001; tick(); clear_strobes();
    chk("R11 pending grown", pending, 3'b111); chk("R11 sel undisturbed", tx_sel, 3'b100);
    chk("R11 no early abort", abort_ack, 0);
    tx_done = 1; tick(); clear_strobes();
    bus_idle = 1; #1; chk("R11 new sel", tx_sel, 3'b010);
    tick(); bus_idle = 0;
    chk("R11 cancel applied", abort_ack, 3'b001);
    tx_done = 1; tick(); clear_strobes();
    wipe_flags();
  endtask

  task automatic t_priority();
    set_wr = 3'b001; tick(); clear_strobes();
    bus_idle = 1; tick(); bus_idle = 0;
    tx_done = 1; bus_err = 1; arb_lost = 1; txack_clr = 3'b001; irq_clr = 1;
    set_wr = 3'b001;
    tick(); clear_strobes();
    chk("R7 done wins", tx_ack, 3'b001); chk("R7 no abort", abort_ack, 0);
    chk("R12 hw set wins irq", empty_irq, 1); chk("R2 set wins clear", pending, 3'b001);
    chk("R7 idle after", busy, 0);
    bus_idle = 1; tick(); bus_idle = 0; tx_done = 1; tick(); clear_strobes();
    wipe_flags();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_cancel_uncommitted();
    t_dis_abort();
    t_retry();
    t_mid_flight();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule